// File: doc/BRIEF.md
# Cascaded 16-bit match timer

This block is a 16-bit up-counter made from two 8-bit stages in cascade. The lower stage counts ticks of a selected source clock. The upper stage advances each time the lower stage wraps. Software loads a 16-bit compare value as two byte writes, low byte first and then high byte. While the run bit is set, the counter steps once per source tick. On the tick at which the count equals the compare value, the block emits a one-cycle interrupt pulse, clears the counter to zero and keeps counting. A compare value N therefore gives one interrupt every N+1 source ticks.

The source tick comes from a free-running prescaler on the system clock, which offers four tap periods. A divider-mode input can replace the slowest tap with every eighth pulse of an external slow-clock tick. The slow-clock tick is already synchronized and one system-clock cycle wide. There is no shadow copy of the compare value, so a byte write is used in the very next comparison. The pulse output of the timer stays low in this mode.

Top module: `cascaded_match_timer`

## Requirements
- R1: During and directly after synchronous reset, `irq` and `tmr_pulse` are 0 and the counter and prescaler are cleared.
- R2: The counter advances by exactly one on each selected source tick, and only while `run` is 1.
- R3: With compare value N, the tick that finds count == N raises `irq` for exactly one system-clock cycle, in the cycle after that tick, and clears the counter. Counting continues, so consecutive pulses are (N+1) x source period apart.
- R4: A write with `cmp_we`=1 stores `cmp_byte` in the low compare byte when `cmp_hi`=0 and in the high byte when `cmp_hi`=1. The new value takes part in the next comparison without waiting for a match.
- R5: With `div_mode`=0, `src_sel` values 0, 1, 2 and 3 select a source period of 2048, 128, 32 and 8 system-clock cycles.
- R6: With `div_mode`=1, `src_sel`=0 selects one source tick per 8 pulses of `slow_tick`. `src_sel` values 1 to 3 keep the periods they have with `div_mode`=0.
- R7: While `run` is 0 the counter is held at 0 and `irq` stays low. When `run` is set again, counting starts from 0.
- R8: A compare value of 0 raises `irq` on every source tick.
- R9: `tmr_pulse` is 0 at all times.
- R10: The upper 8-bit stage advances when the lower stage wraps from 255, so compare values above 255 are reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_we | input | 1 | Compare byte write strobe |
| cmp_hi | input | 1 | Byte select: 0 low, 1 high |
| cmp_byte | input | 8 | Compare byte data |
| run | input | 1 | Start bit. 1 counts, 0 stops and clears |
| src_sel | input | 2 | Source tap select |
| div_mode | input | 1 | 1 replaces the slowest tap with slow_tick/8 |
| slow_tick | input | 1 | Synchronized one-cycle slow-clock tick |
| irq | output | 1 | One-cycle match interrupt pulse |
| tmr_pulse | output | 1 | Timer pulse output, held at 0 |

## Verification
The bench measures the spacing between interrupt pulses for every tap in both divider modes and for compare values above 255. A stage chain without carry would never reach those values, and a wrong tap would scale the spacing. It rewrites the compare value just after a match. A design with a shadow register would show the old 32-cycle spacing once more instead of the new 64-cycle one. It also stops the timer partway through a period and restarts it. A counter that kept its value over the stop would fire too early. A zero compare value must fire on every tick, and a design that checks for a match only after incrementing would miss these pulses.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int STAGE_W  = 8;
    localparam int NSTAGE   = 2;
    localparam int CNT_W    = STAGE_W * NSTAGE;
    localparam int SEL_W    = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;
    localparam int PRE_W    = 11;
    localparam int SLOW_W   = 3;
    localparam int NTAP     = 4;
    localparam int TAP_SHIFT [NTAP] = '{11, 7, 5, 3};

    typedef logic [NSTAGE-1:0][STAGE_W-1:0] stages_t;

    typedef enum logic [1:0] {
        SRC_SLOWEST = 2'd0,
        SRC_SLOW    = 2'd1,
        SRC_FAST    = 2'd2,
        SRC_FASTEST = 2'd3
    } src_e;

    function automatic logic tap_hit(input logic [PRE_W-1:0] c, input int sh);
        logic [PRE_W-1:0] mask;
        mask = PRE_W'((1 << sh) - 1);
        return (c & mask) == mask;
    endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            slow_tick,
    output logic [NTAP-1:0] tap_en,
    output logic            slow_en
);
    logic [PRE_W-1:0]  div_q;
    logic [SLOW_W-1:0] slow_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)            slow_q <= '0;
        else if (slow_tick) slow_q <= slow_q + 1'b1;
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign tap_en[t] = tap_hit(div_q, TAP_SHIFT[t]);
    end

    assign slow_en = slow_tick && (&slow_q);

    // the fastest tap never fires on two cycles in a row
    p_fast_tap_gap_r5: assert property (@(posedge clk) disable iff (rst)
        tap_en[NTAP-1] |=> !tap_en[NTAP-1]);
    // the slow source tick is only issued on a slow-clock pulse
    p_slow_from_tick_r6: assert property (@(posedge clk) disable iff (rst)
        slow_en |-> slow_tick);
endmodule

// File: rtl/cmt_cmp_reg.sv
module cmt_cmp_reg
    import cmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SEL_W-1:0]   sel,
    input  logic [STAGE_W-1:0] din,
    output stages_t            cmp
);
    for (genvar g = 0; g < NSTAGE; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)                            cmp[g] <= '0;
            else if (we && sel == SEL_W'(g))    cmp[g] <= din;
        end
    end

    p_low_write_r4: assert property (@(posedge clk) disable iff (rst)
        (we && sel == '0) |=> cmp[0] == $past(din));
    p_high_write_r4: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_W'(NSTAGE-1)) |=> cmp[NSTAGE-1] == $past(din));
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    tick,
    input  stages_t cmp,
    output logic    irq
);
    stages_t           stg;
    logic [NSTAGE:0]   carry;
    logic              match;
    logic [CNT_W-1:0]  cnt_flat;

    assign carry[0] = tick;
    assign match    = (stg == cmp);
    assign cnt_flat = stg;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        assign carry[g+1] = carry[g] & (&stg[g]);
        always_ff @(posedge clk) begin
            if (rst || !run)        stg[g] <= '0;
            else if (tick && match) stg[g] <= '0;
            else if (carry[g])      stg[g] <= stg[g] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= run && tick && match;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !match) |=> cnt_flat == $past(cnt_flat) + 1'b1);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(cnt_flat));
    p_match_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (run && tick && match) |=> (cnt_flat == '0) && irq);
    p_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    p_stop_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_flat == '0) && !irq);
endmodule

// File: rtl/cascaded_match_timer.sv
module cascaded_match_timer
    import cmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmp_we,
    input  logic        cmp_hi,
    input  logic [7:0]  cmp_byte,
    input  logic        run,
    input  logic [1:0]  src_sel,
    input  logic        div_mode,
    input  logic        slow_tick,
    output logic        irq,
    output logic        tmr_pulse
);
    logic [NTAP-1:0] tap_en;
    logic            slow_en;
    logic            tick;
    stages_t         cmp;
    src_e            src;

    cmt_prescaler u_pre (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .tap_en    (tap_en),
        .slow_en   (slow_en)
    );

    cmt_cmp_reg u_cmp (
        .clk (clk),
        .rst (rst),
        .we  (cmp_we),
        .sel (SEL_W'(cmp_hi)),
        .din (cmp_byte),
        .cmp (cmp)
    );

    assign src = src_e'(src_sel);

    always_comb begin
        unique case (src)
            SRC_SLOWEST: tick = div_mode ? slow_en : tap_en[0];
            SRC_SLOW:    tick = tap_en[1];
            SRC_FAST:    tick = tap_en[2];
            default:     tick = tap_en[3];
        endcase
    end

    cmt_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick),
        .cmp  (cmp),
        .irq  (irq)
    );

    assign tmr_pulse = 1'b0;

    // in divider mode 1 the slowest source never follows the main-clock tap
    p_slow_src_r6: assert property (@(posedge clk) disable iff (rst)
        (div_mode && src == SRC_SLOWEST && tick) |-> slow_tick);
endmodule

// File: tb/cascaded_match_timer_bench.sv
module cascaded_match_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_we = 1'b0, cmp_hi = 1'b0, run = 1'b0, div_mode = 1'b0;
    logic [7:0] cmp_byte = '0;
    logic [1:0] src_sel = 2'd3;
    logic       slow_tick = 1'b0;
    logic       irq, tmr_pulse;
    int         n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    cascaded_match_timer u_cascaded_match_timer (
        .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_hi(cmp_hi),
        .cmp_byte(cmp_byte), .run(run), .src_sel(src_sel),
        .div_mode(div_mode), .slow_tick(slow_tick),
        .irq(irq), .tmr_pulse(tmr_pulse)
    );

    // slow-clock tick: one pulse every 10 system cycles
    initial begin
        forever begin
            repeat (9) @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // counts negedges until irq is seen high; -1 on timeout
    task automatic wait_irq(input int max, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!irq && cyc < max);
        if (!irq) cyc = -1;
    endtask

    task automatic write_cmp(input logic [15:0] v);
        @(negedge clk); cmp_we = 1'b1; cmp_hi = 1'b0; cmp_byte = v[7:0];
        @(negedge clk); cmp_hi = 1'b1; cmp_byte = v[15:8];
        @(negedge clk); cmp_we = 1'b0;
    endtask

    task automatic setup(input logic [15:0] v, input logic [1:0] s, input logic dm);
        @(negedge clk); run = 1'b0;
        write_cmp(v);
        src_sel = s; div_mode = dm;
        @(negedge clk); run = 1'b1;
    endtask

    task automatic interval(input string req, input logic [15:0] v,
                            input logic [1:0] s, input logic dm, input int exp);
        int c;
        setup(v, s, dm);
        wait_irq(exp * 3, c);
        for (int k = 0; k < 2; k++) begin
            wait_irq(exp * 3, c);
            check(req, c, exp);
        end
    endtask

    task automatic t_reset();
        check("R1 irq", int'(irq), 0);
        check("R9 tmr_pulse", int'(tmr_pulse), 0);
    endtask

    task automatic t_taps();
        interval("R3 R5 sel3 cmp5", 16'd5, 2'd3, 1'b0, 48);
        interval("R5 sel2 cmp3", 16'd3, 2'd2, 1'b0, 128);
        interval("R5 sel1 cmp1", 16'd1, 2'd1, 1'b0, 256);
        interval("R5 R8 sel0 cmp0", 16'd0, 2'd0, 1'b0, 2048);
        check("R9 tmr_pulse", int'(tmr_pulse), 0);
    endtask

    task automatic t_slow();
        interval("R6 slow sel0 cmp2", 16'd2, 2'd0, 1'b1, 240);
        interval("R6 slow sel2 cmp1", 16'd1, 2'd2, 1'b1, 64);
    endtask

    task automatic t_zero();
        int c, n;
        setup(16'd0, 2'd3, 1'b0);
        wait_irq(100, c);
        n = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (irq) n++;
        end
        check("R8 irq per tick", n, 10);
    endtask

    task automatic t_carry();
        interval("R10 cmp 0x0105", 16'h0105, 2'd3, 1'b0, 262 * 8);
    endtask

    task automatic t_immediate();
        int c;
        setup(16'd3, 2'd3, 1'b0);
        wait_irq(200, c);
        wait_irq(200, c);
        check("R4 before rewrite", c, 32);
        write_cmp(16'd7);
        wait_irq(300, c);
        check("R4 immediate rewrite", c + 3, 64);
    endtask

    task automatic t_stop();
        int c, n;
        setup(16'd6, 2'd3, 1'b0);
        wait_irq(300, c);
        repeat (24) @(negedge clk);
        run = 1'b0;
        n = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (irq) n++;
        end
        check("R7 no irq while stopped", n, 0);
        run = 1'b1;
        wait_irq(300, c);
        check_range("R7 R2 restart from zero", c, 50, 57);
        check("R9 tmr_pulse", int'(tmr_pulse), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_taps();
        t_slow();
        t_zero();
        t_carry();
        t_immediate();
        t_stop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule